// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a programmed memory mode word into the sequence of column addresses that a synchronous DRAM controller walks during one read or write burst. Software or a controller sequencer loads the mode word once. Each burst then begins with a start strobe that carries the first column. After that the block issues one column per clock, with a valid flag and a flag on the final beat, until the burst is over.

The mode word sets several things: the burst length (1, 2, 4, 8 or a whole 256-column page), the address ordering (wrapping increment or XOR interleave), the read latency, and a single-beat write option. A mode word with an undefined code does not change the held configuration. Instead it raises an error flag that stays set until reset. A stop strobe ends a burst on any beat. A fresh start strobe always takes over at once, even in the middle of a burst.

Top module: `burst_colgen`

## Requirements
- R1: Mode bits 2:0 set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page.
- R2: With mode bit 3 = 0, beat k of a length-L burst starting at column S is the column of S's L-aligned block at offset (S mod L + k) mod L. For example, start 2 with length 4 gives 2,3,0,1.
- R3: With mode bit 3 = 1, beat k is S XOR k. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R4: A full-page burst gives (S + k) mod 256 at every beat. It never raises col_last and stays valid until a stop or a new start. Code 111 together with bit 3 = 1 is undefined.
- R5: Mode bits 6:4 set cas_lat: 010 gives 2 and 011 gives 3.
- R6: A loaded word is undefined in any of these cases: length code 100, 101 or 110; 111 with bit 3 = 1; a latency code other than 010 or 011; bits 8:7 not 00; any bit from 10 upward set. Such a word sets mode_err, which stays high until reset, and it leaves the held configuration and cas_lat unchanged.
- R7: With mode bit 9 set, every write burst is one beat long. Read bursts keep the programmed length.
- R8: burst_halt without burst_go drops col_valid from the next cycle. If both are high in the same cycle, the start wins.
- R9: burst_go during a burst restarts the sequence from the new start column in the next cycle.
- R10: The first column appears with col_valid in the cycle after the burst_go edge. col_last marks the final beat. col_valid falls in the cycle after the final beat.
- R11: After reset the outputs are as follows: col_valid 0, col_last 0, mode_err 0, col_addr 0, cas_lat 2. The held configuration is length 1, sequential ordering, no single-beat write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load mode_word this cycle |
| mode_word | input | MODE_W | Mode word |
| burst_go | input | 1 | Begin a burst at start_col |
| start_col | input | COL_W | First column of the burst |
| is_write | input | 1 | Burst being started is a write |
| burst_halt | input | 1 | Stop the running burst |
| col_addr | output | COL_W | Current column |
| col_valid | output | 1 | col_addr is a burst beat |
| col_last | output | 1 | Final beat of the burst |
| cas_lat | output | 2 | Decoded read latency (2 or 3) |
| mode_err | output | 1 | Sticky flag for an undefined mode word |

## Verification
Each burst length is tried in both orderings with start columns at, below and above the block's low bits. Wrapping increment and XOR differ only when the start is unaligned, so such starts are what separate the two orderings, and a start near the top of a block exposes a wrap that leaks into the block above. The single-beat option is run with a write and with a read under the same word, which shows that the direction decides the length. A page burst is run past column 255, a restart is applied mid-burst, and a stop is applied alone and together with a start. Undefined words of every kind follow a valid word, and a burst after them shows that the earlier length and latency are still in force.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef struct packed {
    logic [2:0] bl;
    logic       ilv;
    logic       lat3;
    logic       brsw;
  } cfg_t;

  localparam logic [2:0] BL_FULL = 3'b111;
  localparam logic [2:0] BL_TOP  = 3'b011;

  localparam cfg_t CFG_RESET = '{bl: 3'b000, ilv: 1'b0, lat3: 1'b0, brsw: 1'b0};

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output cfg_t              cfg,
  output logic              err
);

  cfg_t cfg_q, cfg_d;
  logic err_q, err_d;
  logic bl_ok, lat_ok, op_ok, good, cfg_en;

  always_comb begin
    bl_ok  = (word[2:0] <= BL_TOP) || ((word[2:0] == BL_FULL) && !word[3]);
    lat_ok = (word[6:4] == 3'b010) || (word[6:4] == 3'b011);
    op_ok  = (word[8:7] == 2'b00) && (word[MODE_W-1:10] == '0);
    good   = bl_ok && lat_ok && op_ok;
    cfg_en = load && good;
    cfg_d.bl   = word[2:0];
    cfg_d.ilv  = word[3];
    cfg_d.lat3 = (word[6:4] == 3'b011);
    cfg_d.brsw = word[9];
    err_d  = err_q || (load && !good);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg = cfg_q;
  assign err = err_q;

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic             wr,
  input  logic [COL_W-1:0] start,
  input  logic [2:0]       bl,
  input  logic             ilv,
  input  logic             brsw,
  output logic             valid,
  output logic             last,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] mask,
  output logic             ilv_mode
);

  logic             valid_q, valid_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] base_q, mask_q, mask_new;
  logic             ilv_q, full_q, full_new, single_wr;

  always_comb begin
    single_wr = wr && brsw;
    case (bl)
      3'b000:  mask_new = '0;
      3'b001:  mask_new = COL_W'(1);
      3'b010:  mask_new = COL_W'(3);
      3'b011:  mask_new = COL_W'(7);
      BL_FULL: mask_new = '1;
      default: mask_new = '0;
    endcase
    full_new = (bl == BL_FULL);
    if (single_wr) begin
      mask_new = '0;
      full_new = 1'b0;
    end
  end

  assign last = valid_q && !full_q && (beat_q == mask_q);

  always_comb begin
    valid_d = valid_q;
    beat_d  = beat_q;
    if (go) begin
      valid_d = 1'b1;
      beat_d  = '0;
    end else if (halt) begin
      valid_d = 1'b0;
    end else if (valid_q) begin
      if (last) valid_d = 1'b0;
      else      beat_d  = beat_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      valid_q <= valid_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (go) begin
      base_q <= start;
      mask_q <= mask_new;
      ilv_q  <= ilv;
      full_q <= full_new;
    end
  end

  assign valid    = valid_q;
  assign base     = base_q;
  assign beat     = beat_q;
  assign mask     = mask_q;
  assign ilv_mode = ilv_q;

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] sum;

  assign sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign addr[i] = mask[i] ? (ilv ? (base[i] ^ beat[i]) : sum[i]) : base[i];
  end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              burst_go,
  input  logic [COL_W-1:0]  start_col,
  input  logic              is_write,
  input  logic              burst_halt,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              col_last,
  output logic [1:0]        cas_lat,
  output logic              mode_err
);

  cfg_t             cfg;
  logic [COL_W-1:0] base, beat, mask;
  logic             ilv_mode;

  colgen_mode_dec #(.MODE_W(MODE_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .word  (mode_word),
    .cfg   (cfg),
    .err   (mode_err)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (burst_go),
    .halt     (burst_halt),
    .wr       (is_write),
    .start    (start_col),
    .bl       (cfg.bl),
    .ilv      (cfg.ilv),
    .brsw     (cfg.brsw),
    .valid    (col_valid),
    .last     (col_last),
    .base     (base),
    .beat     (beat),
    .mask     (mask),
    .ilv_mode (ilv_mode)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base (base),
    .beat (beat),
    .mask (mask),
    .ilv  (ilv_mode),
    .addr (col_addr)
  );

  assign cas_lat = cfg.lat3 ? 2'd3 : 2'd2;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic [2:0]       lat_code,
  input logic             burst_go,
  input logic [COL_W-1:0] start_col,
  input logic             burst_halt,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last,
  input logic [1:0]       cas_lat,
  input logic             mode_err
);

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) col_last |-> col_valid); // R10
  AST_GO_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n) burst_go |=> (col_valid && col_addr == $past(start_col))); // R9
  AST_HALT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (burst_halt && !burst_go) |=> !col_valid); // R8
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (col_last && !burst_go) |=> !col_valid); // R10
  AST_KEEP_GOING: assert property (@(posedge clk) disable iff (!rst_n) (col_valid && !col_last && !burst_go && !burst_halt) |=> col_valid); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) mode_err |=> mode_err); // R6
  AST_BAD_LAT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (mode_load && lat_code != 3'b010 && lat_code != 3'b011) |=> (mode_err && $stable(cas_lat))); // R6

endmodule

bind burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_load  (mode_load),
  .lat_code   (mode_word[6:4]),
  .burst_go   (burst_go),
  .start_col  (start_col),
  .burst_halt (burst_halt),
  .col_addr   (col_addr),
  .col_valid  (col_valid),
  .col_last   (col_last),
  .cas_lat    (cas_lat),
  .mode_err   (mode_err)
);

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;

  logic        clk;
  logic        rst_n;
  logic        mode_load;
  logic [11:0] mode_word;
  logic        burst_go;
  logic [7:0]  start_col;
  logic        is_write;
  logic        burst_halt;
  logic [7:0]  col_addr;
  logic        col_valid;
  logic        col_last;
  logic [1:0]  cas_lat;
  logic        mode_err;

  int nchk  = 0;
  int nfail = 0;

  burst_colgen u0 (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .burst_go(burst_go), .start_col(start_col), .is_write(is_write),
    .burst_halt(burst_halt), .col_addr(col_addr), .col_valid(col_valid),
    .col_last(col_last), .cas_lat(cas_lat), .mode_err(mode_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [11:0] mode;
    logic [7:0]  start;
    logic        wr;
    logic [8:0]  len;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{12'h020, 8'h37, 1'b0, 9'd1, 2'd2},
    '{12'h021, 8'h11, 1'b0, 9'd2, 2'd2},
    '{12'h022, 8'h02, 1'b0, 9'd4, 2'd2},
    '{12'h023, 8'h2D, 1'b0, 9'd8, 2'd2},
    '{12'h02B, 8'h05, 1'b0, 9'd8, 2'd2},
    '{12'h02A, 8'h43, 1'b0, 9'd4, 2'd2},
    '{12'h029, 8'hFF, 1'b0, 9'd2, 2'd2},
    '{12'h033, 8'h9A, 1'b1, 9'd8, 2'd3},
    '{12'h233, 8'h9A, 1'b1, 9'd1, 2'd3},
    '{12'h233, 8'h1E, 1'b0, 9'd8, 2'd3}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [11:0] mode, input logic [7:0] s,
                                         input int k, input int len);
    int off;
    if (len == 256) return 8'((int'(s) + k) % 256);
    if (mode[3]) return s ^ 8'(k);
    off = int'(s) % len;
    return 8'(int'(s) - off + ((off + k) % len));
  endfunction

  task automatic load(input logic [11:0] w);
    mode_load = 1'b1;
    mode_word = w;
    tick();
    mode_load = 1'b0;
  endtask

  task automatic burst(input string tag, input logic [11:0] mode, input logic [7:0] s,
                       input logic wr, input int len);
    burst_go  = 1'b1;
    start_col = s;
    is_write  = wr;
    tick();
    burst_go = 1'b0;
    for (int k = 0; k < len; k++) begin
      chk({tag, " addr"}, 32'(col_addr), 32'(exp_col(mode, s, k, len)));
      chk({tag, " R10 valid"}, 32'(col_valid), 32'd1);
      chk({tag, " R10 last"}, 32'(col_last), 32'(k == len - 1));
      tick();
    end
    chk({tag, " R1 end of burst"}, 32'(col_valid), 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_word = '0; burst_go = 1'b0;
    start_col = '0; is_write = 1'b0; burst_halt = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 valid", 32'(col_valid), 32'd0);
    chk("R11 last", 32'(col_last), 32'd0);
    chk("R11 err", 32'(mode_err), 32'd0);
    chk("R11 addr", 32'(col_addr), 32'd0);
    chk("R11 lat", 32'(cas_lat), 32'd2);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    burst("R11 default length", 12'h020, 8'h55, 1'b0, 1);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = VECS[v].mode[9] ? "R7" : (VECS[v].mode[3] ? "R3" : "R2");
      load(VECS[v].mode);
      chk("R5 latency", 32'(cas_lat), 32'(VECS[v].lat));
      burst(tag, VECS[v].mode, VECS[v].start, VECS[v].wr, int'(VECS[v].len));
    end

    load(12'h027);
    burst_go = 1'b1; start_col = 8'hFC; is_write = 1'b0;
    tick();
    burst_go = 1'b0;
    for (int k = 0; k < 260; k++) begin
      chk("R4 page addr", 32'(col_addr), 32'((8'hFC + k) % 256));
      chk("R4 page no last", 32'(col_last), 32'd0);
      chk("R4 page valid", 32'(col_valid), 32'd1);
      if (k == 259) burst_halt = 1'b1;
      tick();
    end
    burst_halt = 1'b0;
    chk("R8 halt page", 32'(col_valid), 32'd0);

    load(12'h023);
    burst_go = 1'b1; start_col = 8'h10;
    tick();
    burst_go = 1'b0;
    tick(); tick();
    chk("R9 before restart", 32'(col_addr), 32'h12);
    burst("R9 restart", 12'h023, 8'h44, 1'b0, 8);

    burst_go = 1'b1; start_col = 8'h08;
    tick();
    burst_go = 1'b0;
    tick();
    burst_halt = 1'b1;
    tick();
    burst_halt = 1'b0;
    chk("R8 halt mid", 32'(col_valid), 32'd0);
    burst_go = 1'b1; start_col = 8'h20;
    tick();
    burst_halt = 1'b1; start_col = 8'h30;
    tick();
    burst_go = 1'b0; burst_halt = 1'b0;
    chk("R8 go wins valid", 32'(col_valid), 32'd1);
    chk("R8 go wins addr", 32'(col_addr), 32'h30);
    tick(); tick(); tick(); tick(); tick(); tick(); tick(); tick();

    load(12'h032);
    chk("R5 lat3", 32'(cas_lat), 32'd3);
    chk("R6 no err", 32'(mode_err), 32'd0);
    load(12'h02C);
    chk("R6 err len", 32'(mode_err), 32'd1);
    load(12'h02F);
    load(12'h042);
    chk("R6 lat kept", 32'(cas_lat), 32'd3);
    load(12'h0B2);
    load(12'h432);
    chk("R6 err sticky", 32'(mode_err), 32'd1);
    chk("R6 lat still", 32'(cas_lat), 32'd3);
    burst("R6 config kept", 12'h032, 8'h06, 1'b0, 4);

    rst_n = 1'b0;
    tick();
    chk("R11 err cleared", 32'(mode_err), 32'd0);
    chk("R11 lat reset", 32'(cas_lat), 32'd2);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule